// File: doc/BRIEF.md
# Programmable Dead-Band Generator

This block turns three PWM phase signals into three complementary output pairs. Each pair has a true output that follows the phase and a complement output that follows its inverse. After every edge of a phase, the output that is about to turn on waits for a programmable dead time. During that wait both outputs of the pair are low, so the two switches of a half-bridge are never driven on at the same moment.

The dead time is a 4-bit period value multiplied by a prescale ratio, counted in cycles of the block clock. Each phase has its own enable bit. A phase that is not enabled passes its input straight through as a plain complementary pair.

All settings come from a single 16-bit control word, which the surrounding logic holds steady. The phase inputs are sampled on the clock, and every output is a function of registered state only.

Top module: `dead_band_gen`

## Requirements
- R1: The control word fields are as follows. The dead-band period is in bits 11:8. The prescale code is in bits 4:2. The enables are in bits 5, 6 and 7, for phase 0, phase 1 and phase 2 respectively. Bits 15:12 and 1:0 have no effect on the outputs.
- R2: The prescale code sets the ratio as follows: 0→1, 1→2, 2→4, 3→8, 4→16. Codes 5, 6 and 7 all give 32.
- R3: For an enabled phase, a rising input edge is sampled at a clock edge E. The complement output goes low after E. The true output stays low for exactly period×ratio further clock edges and then goes high.
- R4: For an enabled phase, a falling input edge is sampled at a clock edge E. The true output goes low after E. The complement output stays low for exactly period×ratio further clock edges and then goes high.
- R5: The true output and the complement output of one phase are never high at the same time.
- R6: For a phase whose enable bit is 0, the true output equals the input as sampled at the previous clock edge, and the complement output is its inverse.
- R7: For an enabled phase with a period of 0, the outputs behave exactly as for a disabled phase.
- R8: If the input changes again during a dead time, the dead-time count restarts from the new edge. Both outputs stay low until the full dead time after that new edge has passed.
- R9: While reset is active, every true output is 0 and every complement output is 1.
- R10: Each phase times its own dead time. A disabled phase passes its input through while the other phases insert dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; dead time is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 16 | Control word: period, enables, prescale code |
| ph_in | input | 3 | PWM phase inputs, bit i is phase i |
| dt_p | output | 3 | True outputs with dead time, bit i for phase i |
| dt_n | output | 3 | Complement outputs with dead time, bit i for phase i |

## Verification
The bench builds the block with its default parameters: three phases, a 4-bit period and a 3-bit prescale code. With these values, all eight prescale codes can be exercised, including the three codes that saturate at 32. The longest dead time, 15×32 = 480 cycles, is also within reach. Each vector pairs a control word with a phase and with a dead-time length worked out from the field layout. The bench counts the output's low cycles after a rising edge and after a falling edge, and compares each count with that length. Directed cases then cover reset, a retriggered edge and a disabled phase beside enabled ones.

// File: rtl/dead_band_gen.sv
module dead_band_gen #(
  parameter int NUM_PH  = 3,
  parameter int CTRL_W  = 16,
  parameter int PRD_W   = 4,
  parameter int PS_W    = 3,
  parameter int PRD_LSB = 8,
  parameter int EN_LSB  = 5,
  parameter int PS_LSB  = 2,
  parameter int MAX_SH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [NUM_PH-1:0] ph_in,
  output logic [NUM_PH-1:0] dt_p,
  output logic [NUM_PH-1:0] dt_n
);
  localparam int PRE_W = MAX_SH;

  logic [PRD_W-1:0]  prd;
  logic [PS_W-1:0]   ps_code;
  logic [PS_W-1:0]   shift;
  logic [NUM_PH-1:0] en;
  logic [PRE_W-1:0]  pre_lim;

  assign prd     = ctrl[PRD_LSB +: PRD_W];
  assign ps_code = ctrl[PS_LSB +: PS_W];
  assign en      = ctrl[EN_LSB +: NUM_PH];
  assign shift   = (int'(ps_code) > MAX_SH) ? PS_W'(MAX_SH) : ps_code;
  assign pre_lim = PRE_W'((32'd1 << shift) - 32'd1);

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    logic             prev_q, busy_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRD_W-1:0] cnt_q;
    logic [PRD_W:0]   cnt_nx;
    logic             edge_w, tick, last;

    assign edge_w = ph_in[i] ^ prev_q;
    assign tick   = (pre_q == pre_lim);
    assign cnt_nx = {1'b0, cnt_q} + {{PRD_W{1'b0}}, 1'b1};
    assign last   = tick && (cnt_nx >= {1'b0, prd});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        busy_q <= 1'b0;
        pre_q  <= '0;
        cnt_q  <= '0;
      end else if (edge_w) begin
        prev_q <= ph_in[i];
        busy_q <= (prd != '0);
        pre_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (tick) begin
          pre_q <= '0;
          cnt_q <= cnt_nx[PRD_W-1:0];
          if (last) busy_q <= 1'b0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end

    assign dt_p[i] =  prev_q & ~(busy_q & en[i]);
    assign dt_n[i] = ~prev_q & ~(busy_q & en[i]);
  end
endmodule

// File: rtl/dead_band_gen_chk.sv
module dead_band_gen_chk #(
  parameter int NUM_PH = 3,
  parameter int CTRL_W = 16,
  parameter int EN_LSB = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl,
  input logic [NUM_PH-1:0] ph_in,
  input logic [NUM_PH-1:0] dt_p,
  input logic [NUM_PH-1:0] dt_n
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  always_comb if (!rst_n) a_reset_state_r9: assert (dt_p == '0 && dt_n == '1);

  for (genvar i = 0; i < NUM_PH; i++) begin : g_chk
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(dt_p[i] && dt_n[i]));
    p_true_follows_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && dt_p[i]) |-> $past(ph_in[i]));
    p_comp_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && dt_n[i]) |-> !$past(ph_in[i]));
    p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !ctrl[EN_LSB+i]) |-> (dt_p[i] == $past(ph_in[i]) && dt_n[i] == !dt_p[i]));
  end
endmodule

bind dead_band_gen dead_band_gen_chk #(
  .NUM_PH(NUM_PH), .CTRL_W(CTRL_W), .EN_LSB(EN_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ph_in(ph_in), .dt_p(dt_p), .dt_n(dt_n)
);

// File: tb/dead_band_gen_tb_top.sv
module dead_band_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = 16'h0000;
  logic [2:0]  ph = 3'b000;
  logic [2:0]  dt_p, dt_n;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dead_band_gen dut_i (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ph_in(ph),
                       .dt_p(dt_p), .dt_n(dt_n));

  // {ctrl, phase index, expected dead cycles}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {16'h03E0, 2'd0, 10'd3},   // R2 code 0 ratio 1
    {16'h05E4, 2'd1, 10'd10},  // R2 code 1 ratio 2
    {16'h02E8, 2'd2, 10'd8},   // R2 code 2 ratio 4
    {16'h01EC, 2'd0, 10'd8},   // R2 code 3 ratio 8
    {16'h02F0, 2'd1, 10'd32},  // R2 code 4 ratio 16
    {16'h01F4, 2'd2, 10'd32},  // R2 code 5 saturates
    {16'h01F8, 2'd0, 10'd32},  // R2 code 6 saturates
    {16'h02FC, 2'd1, 10'd64},  // R2 code 7 saturates
    {16'h0FE0, 2'd2, 10'd15},  // R3 full period
    {16'h00EC, 2'd0, 10'd0},   // R7 period zero
    {16'h07C0, 2'd0, 10'd0},   // R6 R10 phase 0 disabled
    {16'hF4E7, 2'd2, 10'd8}    // R1 reserved bits set
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int idx, input bit rise, input int exp_n, input string tag);
    int cnt = 0;
    bit seen = 1'b0;
    bit ovl = 1'b0;
    @(negedge clk);
    ph[idx] = rise;
    for (int k = 0; k < 600 && !seen; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (dt_p[idx] && dt_n[idx]) ovl = 1'b1;
      if (rise ? dt_p[idx] : dt_n[idx]) seen = 1'b1;
      else begin
        cnt++;
        if (dt_p[idx] || dt_n[idx]) ovl = 1'b1;
      end
    end
    check(cnt == exp_n, tag, cnt, exp_n);
    check(!ovl, "R5 both low in dead time", int'(ovl), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dt_p == 3'b000, "R9 reset true outputs", int'(dt_p), 0);
    check(dt_n == 3'b111, "R9 reset complement outputs", int'(dt_n), 7);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ctrl = VEC[v][27:12];
      ph = 3'b000;
      repeat (520) @(negedge clk);
      measure(int'(VEC[v][11:10]), 1'b1, int'(VEC[v][9:0]), "R3 rising dead time");
      repeat (520) @(negedge clk);
      measure(int'(VEC[v][11:10]), 1'b0, int'(VEC[v][9:0]), "R4 falling dead time");
    end

    // R10: phase 0 disabled passes through while phase 1 waits out its dead time
    @(negedge clk);
    ctrl = 16'h07C0;
    ph = 3'b000;
    repeat (520) @(negedge clk);
    ph = 3'b011;
    @(posedge clk);
    @(negedge clk);
    check(dt_p[0] == 1'b1, "R10 disabled phase follows", int'(dt_p[0]), 1);
    check(dt_p[1] == 1'b0 && dt_n[1] == 1'b0, "R10 enabled phase in dead time",
          int'({dt_p[1], dt_n[1]}), 0);

    // R8: retrigger inside the dead time
    @(negedge clk);
    ctrl = 16'h04E0;
    ph = 3'b000;
    repeat (520) @(negedge clk);
    ph[0] = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(dt_p[0] == 1'b0 && dt_n[0] == 1'b0, "R8 both low before retrigger",
            int'({dt_p[0], dt_n[0]}), 0);
    end
    measure(0, 1'b0, 4, "R8 dead time restarts");
    check(dt_p[0] == 1'b0, "R8 true output stays low", int'(dt_p[0]), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule